// File: doc/BRIEF.md
# Fixed-Point Fraction to Base-100 Digit Formatter

This block takes an unsigned fixed-point word with a 7-bit integer field and a 14-bit fraction field and turns it into four 7-bit display values. The first value is the integer field. The second value is a constant zero that holds the place of the decimal point. The third and fourth values are base-100 digits of the fraction. The third gives decimal places one and two, and the fourth gives decimal places three and four. A downstream segment decoder, which is not part of this block, turns each value into a display pattern.

The fraction is converted by multiplying by 100 and keeping the part above the binary point. The remainder below the binary point goes to a second multiply-by-100 stage. Both stages are shift-and-add networks that settle in the same clock cycle. The block also receives the operands that produced the word: a 7-bit radicand and a 6-bit root order. It raises an error flag when either operand is out of range.

A controller with three states handles the timing. The states are IDLE (no result captured since reset), SHOW (a result was captured on the previous edge) and HOLD (an older result is kept on the outputs). A strobe moves the controller to SHOW from any state. In SHOW, a cycle with no strobe moves it to HOLD. IDLE and HOLD stay where they are until a strobe arrives. The output `out_valid` is high only in SHOW.

Top module: `frac_base100_fmt`

## Requirements
- R1: After reset, `out_valid`, `err` and all four digit outputs are 0.
- R2: `out_valid` is high for exactly one cycle on the clock edge after each cycle where `in_valid` is high, and it stays low when no strobe came in the previous cycle.
- R3: On a strobe, `dig_int` takes bits [20:14] of `fixed_in`.
- R4: `dig_point` is always 0.
- R5: On a strobe, `dig_frac_hi` takes floor(F*100 / 2^14), where F is `fixed_in[13:0]`. The result is always in 0..99.
- R6: On a strobe, `dig_frac_lo` takes floor(F*10000 / 2^14) mod 100. It is computed as floor(((F*100) mod 2^14) * 100 / 2^14) and is always in 0..99.
- R7: On a strobe, `err` becomes 1 if `x_in` > 99, `n_in` < 1 or `n_in` > 63. Otherwise it becomes 0.
- R8: Cycles without a strobe have no effect on `dig_int`, `dig_frac_hi`, `dig_frac_lo` or `err`, even when the data inputs change.
- R9: The input word 000100001001110011111 gives digits 8, 0, 30 and 65.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures the inputs |
| fixed_in | input | 21 | Fixed-point value: 7 integer bits above 14 fraction bits |
| x_in | input | 7 | Radicand operand, checked for range |
| n_in | input | 6 | Root-order operand, checked for range |
| out_valid | output | 1 | One-cycle pulse when new digits are present |
| dig_int | output | 7 | Integer part |
| dig_point | output | 7 | Decimal-point placeholder, always 0 |
| dig_frac_hi | output | 7 | Decimal places one and two, base 100 |
| dig_frac_lo | output | 7 | Decimal places three and four, base 100 |
| err | output | 1 | Operand range error |

## Verification
The assertions check these properties on every cycle: the one-cycle valid pulse after each strobe and its absence otherwise, the constant zero point digit, both fraction digits staying below 100, the integer and error values captured from the strobed inputs, and the outputs holding steady between strobes. The exact base-100 fraction values cannot be shown by a property without copying the arithmetic. The bench's scenarios cover them instead: the reference word, zero and full-scale fractions, pseudo-random words checked against the multiply-by-10000 formula, operand values on both sides of each range limit, and back-to-back strobes.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    // width of each display value
    localparam int DIGIT_W = 7;
    // base of each fraction digit
    localparam int RADIX   = 100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOW = 2'd1,
        ST_HOLD = 2'd2
    } fmt_state_e;
endpackage

// File: rtl/fmt_mul100_stage.sv
// One multiply-by-100 stage: 100*x = 64x + 32x + 4x.
// The part above the binary point becomes a base-100 digit, and the
// part below it feeds the next stage.
module fmt_mul100_stage #(
    parameter int FRAC_W  = 14,
    parameter int DIGIT_W = 7
) (
    input  logic [FRAC_W-1:0]  frac_in,
    output logic [DIGIT_W-1:0] digit,
    output logic [FRAC_W-1:0]  frac_rem
);
    localparam int PROD_W = FRAC_W + DIGIT_W;

    logic [PROD_W-1:0] ext;
    logic [PROD_W-1:0] prod;

    always_comb begin
        ext      = PROD_W'(frac_in);
        prod     = (ext << 6) + (ext << 5) + (ext << 2);
        digit    = prod[PROD_W-1:FRAC_W];
        frac_rem = prod[FRAC_W-1:0];
    end
endmodule

// File: rtl/fmt_range_chk.sv
// Operand range check: radicand above its limit, or root order outside its window.
module fmt_range_chk #(
    parameter int XW    = 7,
    parameter int NW    = 6,
    parameter int X_MAX = 99,
    parameter int N_MIN = 1,
    parameter int N_MAX = 63
) (
    input  logic [XW-1:0] x_val,
    input  logic [NW-1:0] n_val,
    output logic          bad
);
    int x_i;
    int n_i;

    always_comb begin
        x_i = int'(x_val);
        n_i = int'(n_val);
        bad = (x_i > X_MAX) || (n_i < N_MIN) || (n_i > N_MAX);
    end
endmodule

// File: rtl/frac_base100_fmt.sv
module frac_base100_fmt #(
    parameter int W_INT     = 7,
    parameter int W_FRAC    = 14,
    parameter int NUM_STAGE = 2,
    parameter int XW        = 7,
    parameter int NW        = 6,
    parameter int X_MAX     = 99,
    parameter int N_MIN     = 1,
    parameter int N_MAX     = 63
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [W_INT+W_FRAC-1:0]    fixed_in,
    input  logic [XW-1:0]              x_in,
    input  logic [NW-1:0]              n_in,
    output logic                       out_valid,
    output logic [fmt_pkg::DIGIT_W-1:0] dig_int,
    output logic [fmt_pkg::DIGIT_W-1:0] dig_point,
    output logic [fmt_pkg::DIGIT_W-1:0] dig_frac_hi,
    output logic [fmt_pkg::DIGIT_W-1:0] dig_frac_lo,
    output logic                       err
);
    import fmt_pkg::*;

    localparam int WORD_W = W_INT + W_FRAC;

    // ---------------- fraction digit chain ----------------
    logic [W_FRAC-1:0]  frac_link [NUM_STAGE+1];
    logic [DIGIT_W-1:0] frac_dig  [NUM_STAGE];

    assign frac_link[0] = fixed_in[W_FRAC-1:0];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STAGE; gi++) begin : g_stage
            fmt_mul100_stage #(
                .FRAC_W (W_FRAC),
                .DIGIT_W(DIGIT_W)
            ) u_stage (
                .frac_in (frac_link[gi]),
                .digit   (frac_dig[gi]),
                .frac_rem(frac_link[gi+1])
            );
        end
    endgenerate

    // ---------------- operand range check ----------------
    logic range_bad;

    fmt_range_chk #(
        .XW   (XW),
        .NW   (NW),
        .X_MAX(X_MAX),
        .N_MIN(N_MIN),
        .N_MAX(N_MAX)
    ) u_range (
        .x_val(x_in),
        .n_val(n_in),
        .bad  (range_bad)
    );

    // ---------------- controller ----------------
    fmt_state_e state_q;
    fmt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_SHOW;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_HOLD;
            ST_HOLD: if (in_valid) state_d = ST_SHOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- output registers ----------------
    logic [DIGIT_W-1:0] int_q;
    logic [DIGIT_W-1:0] hi_q;
    logic [DIGIT_W-1:0] lo_q;
    logic               err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            err_q <= 1'b0;
        end else if (in_valid) begin
            int_q <= DIGIT_W'(fixed_in[WORD_W-1:W_FRAC]);
            hi_q  <= frac_dig[0];
            lo_q  <= frac_dig[NUM_STAGE-1];
            err_q <= range_bad;
        end
    end

    assign out_valid   = (state_q == ST_SHOW);
    assign dig_int     = int_q;
    assign dig_point   = '0;
    assign dig_frac_hi = hi_q;
    assign dig_frac_lo = lo_q;
    assign err         = err_q;
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
    parameter int W_INT  = 7,
    parameter int W_FRAC = 14,
    parameter int XW     = 7,
    parameter int NW     = 6,
    parameter int X_MAX  = 99,
    parameter int N_MIN  = 1,
    parameter int N_MAX  = 63
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [W_INT+W_FRAC-1:0] fixed_in,
    input logic [XW-1:0]           x_in,
    input logic [NW-1:0]           n_in,
    input logic                    out_valid,
    input logic [6:0]              dig_int,
    input logic [6:0]              dig_point,
    input logic [6:0]              dig_frac_hi,
    input logic [6:0]              dig_frac_lo,
    input logic                    err
);
    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_int_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dig_int == $past(fixed_in[W_INT+W_FRAC-1:W_FRAC])));

    p_point_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dig_point == 7'd0);

    p_hi_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dig_frac_hi < 7'd100);

    p_lo_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dig_frac_lo < 7'd100);

    p_err_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (err == ((int'($past(x_in)) > X_MAX) ||
                              (int'($past(n_in)) < N_MIN) ||
                              (int'($past(n_in)) > N_MAX))));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dig_int) && $stable(dig_frac_hi) &&
                       $stable(dig_frac_lo) && $stable(err)));
endmodule

bind frac_base100_fmt fmt_checker #(
    .W_INT (W_INT),
    .W_FRAC(W_FRAC),
    .XW    (XW),
    .NW    (NW),
    .X_MAX (X_MAX),
    .N_MIN (N_MIN),
    .N_MAX (N_MAX)
) u_fmt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .fixed_in   (fixed_in),
    .x_in       (x_in),
    .n_in       (n_in),
    .out_valid  (out_valid),
    .dig_int    (dig_int),
    .dig_point  (dig_point),
    .dig_frac_hi(dig_frac_hi),
    .dig_frac_lo(dig_frac_lo),
    .err        (err)
);

// File: tb/frac_base100_fmt_bench.sv
module frac_base100_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [20:0] fixed_in = '0;
    logic [6:0]  x_in = '0;
    logic [5:0]  n_in = 6'd1;
    logic        out_valid;
    logic [6:0]  dig_int, dig_point, dig_frac_hi, dig_frac_lo;
    logic        err;

    always #5 clk = ~clk;

    frac_base100_fmt u_frac_base100_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fixed_in(fixed_in),
        .x_in(x_in), .n_in(n_in), .out_valid(out_valid), .dig_int(dig_int),
        .dig_point(dig_point), .dig_frac_hi(dig_frac_hi),
        .dig_frac_lo(dig_frac_lo), .err(err)
    );

    typedef struct {
        int d_int;
        int d_hi;
        int d_lo;
        int e;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    int last_int = 0, last_hi = 0, last_lo = 0, last_err = 0;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // driver: computes the expected digits and pushes them to the scoreboard
    task automatic send(input int ip, input int fr, input int x, input int n);
        exp_t e;
        longint f;
        f       = longint'(fr);
        e.d_int = ip;
        e.d_hi  = int'((f * 100) >> 14);
        e.d_lo  = int'(((f * 10000) >> 14) % 100);
        e.e     = (x > 99 || n < 1 || n > 63) ? 1 : 0;
        exp_q.push_back(e);
        @(negedge clk);
        fixed_in = {7'(ip), 14'(fr)};
        x_in     = 7'(x);
        n_in     = 6'(n);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops and compares whenever a result appears
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4 point digit", int'(dig_point), 0);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R3 integer digit", int'(dig_int), e.d_int);
                    chk("R5 fraction hi digit", int'(dig_frac_hi), e.d_hi);
                    chk("R6 fraction lo digit", int'(dig_frac_lo), e.d_lo);
                    chk("R7 error flag", int'(err), e.e);
                    last_int = e.d_int; last_hi = e.d_hi;
                    last_lo = e.d_lo;   last_err = e.e;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 dig_int", int'(dig_int), 0);
        chk("R1 dig_frac_hi", int'(dig_frac_hi), 0);
        chk("R1 dig_frac_lo", int'(dig_frac_lo), 0);
        chk("R1 err", int'(err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle no valid", int'(out_valid), 0);

        // R9: reference word 000100001001110011111 -> 8, 0, 30, 65
        send(8, 14'b01001110011111, 69, 2);
        chk("R9 digit one", int'(dig_int), 8);
        chk("R9 digit two", int'(dig_point), 0);
        chk("R9 digit three", int'(dig_frac_hi), 30);
        chk("R9 digit four", int'(dig_frac_lo), 65);
        @(negedge clk);
        chk("R2 pulse one cycle", int'(out_valid), 0);

        // R5/R6 boundaries: zero and full-scale fractions
        send(0, 0, 0, 1);
        send(127, 16383, 99, 63);
        send(1, 8192, 1, 1);
        // R7: operand range limits
        send(3, 100, 100, 5);
        send(3, 100, 99, 0);
        send(3, 100, 127, 63);
        send(3, 100, 50, 63);

        // R8: change inputs without a strobe; outputs must hold
        @(negedge clk);
        fixed_in = 21'h1FFFFF; x_in = 7'd120; n_in = 6'd0;
        repeat (3) @(negedge clk);
        chk("R8 hold int", int'(dig_int), last_int);
        chk("R8 hold hi", int'(dig_frac_hi), last_hi);
        chk("R8 hold lo", int'(dig_frac_lo), last_lo);
        chk("R8 hold err", int'(err), last_err);
        chk("R2 no valid without strobe", int'(out_valid), 0);

        // back-to-back strobes: R2 pulse on each consecutive edge
        @(negedge clk);
        exp_q.push_back('{d_int: 5, d_hi: int'((64'd1234 * 100) >> 14),
                          d_lo: int'(((64'd1234 * 10000) >> 14) % 100), e: 0});
        exp_q.push_back('{d_int: 6, d_hi: int'((64'd4321 * 100) >> 14),
                          d_lo: int'(((64'd4321 * 10000) >> 14) % 100), e: 1});
        fixed_in = {7'd5, 14'd1234}; x_in = 7'd10; n_in = 6'd3; in_valid = 1'b1;
        @(negedge clk);
        fixed_in = {7'd6, 14'd4321}; x_in = 7'd101; n_in = 6'd3;
        @(negedge clk);
        in_valid = 1'b0;

        // pseudo-random words
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 40; i++) begin
            lfsr = lfsr * 1103515245 + 12345;
            send((lfsr >>> 16) & 127, (lfsr >>> 2) & 16383, (lfsr >>> 9) & 127,
                 (lfsr >>> 23) & 63);
        end

        repeat (3) @(negedge clk);
        chk("R2 every strobe answered", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule